// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block counts clock cycles in a free-running 32-bit counter and holds a 32-bit compare value beside it. Both values sit in a numbered control-register space. The counter is register 9 and the compare value is register 11. A write port with an enable, a register number and data loads either register. A read port, addressed by register number, returns either one. Every other number reads as zero and ignores writes.

When the counter reaches the compare value, the block latches a timer-pending flag. The flag stays set until software writes the compare register. Reloading the counter does not clear it. The block also drives an interrupt request, which is the pending flag gated by bit 7 of an interrupt mask and by a global interrupt enable. Arbitration against other interrupt sources and the processor's vectoring are left to the surrounding logic.

Top module: `cycle_timer`

## Requirements
- R1: While reset is active, the counter, the compare value and the pending flag are all zero.
- R2: Without a counter write, the counter grows by one on every clock edge. It wraps from 0xFFFFFFFF to 0, and the wrap alone never sets the pending flag.
- R3: A write to register number 9 loads the counter. The loaded value is visible after that clock edge, and it replaces the increment for that cycle.
- R4: A write to register number 11 loads the compare value, which is visible after that clock edge.
- R5: The read port returns the counter for number 9, the compare value for number 11, and zero for any other number.
- R6: At a clock edge where the counter equals the compare value, the pending flag becomes 1. Once set, it stays set.
- R7: A compare write clears the pending flag at that edge. A counter write leaves the flag unchanged.
- R8: If a compare write and a match fall on the same edge, the flag ends up clear. It sets again only on a later match against the new compare value.
- R9: The interrupt request is 1 exactly when the pending flag, bit 7 of the interrupt mask and the global enable are all 1. The other mask bits have no effect.
- R10: A write to any register number other than 9 or 11 changes neither the counter, nor the compare value, nor the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register number of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Register number of the read |
| rdData | output | 32 | Read data (combinational) |
| intMask | input | 8 | Interrupt mask; bit 7 gates the timer |
| globalEn | input | 1 | Global interrupt enable |
| timerPending | output | 1 | Sticky timer-pending flag |
| timerIrq | output | 1 | Masked timer interrupt request |

## Verification
A vector table loads a counter start value and a compare value, then waits a number of cycles. Each row decides whether the match falls inside the waiting window, just after its last cycle, or never. This separates an off-by-one in when the match is sampled from a correct design. Two rows start just below the wrap point, one with the compare value at zero and one just past it, so that a flag raised by the wrap itself stands apart from a genuine match. Directed tests add the following cases:
- a counter reload while the flag is set;
- a compare write on the very edge of a match;
- writes to unmapped register numbers;
- the mask and enable combinations, including a mask with every bit except bit 7 set.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes from the decode control to the register datapath
  typedef struct packed {
    logic loadCount;
    logic loadCompare;
    logic selCount;
    logic selCompare;
  } timerStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int COUNT_REG   = 9,
  parameter int COMPARE_REG = 11
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output timerStrobes_t     strobes
);
  localparam logic [ADDR_W-1:0] CountNum   = ADDR_W'(COUNT_REG);
  localparam logic [ADDR_W-1:0] CompareNum = ADDR_W'(COMPARE_REG);

  always_comb begin
    strobes.loadCount   = wrEn && (wrAddr == CountNum);
    strobes.loadCompare = wrEn && (wrAddr == CompareNum);
    strobes.selCount    = (rdAddr == CountNum);
    strobes.selCompare  = (rdAddr == CompareNum);
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int MASK_W   = 8,
  parameter int MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerStrobes_t     strobes,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [MASK_W-1:0] intMask,
  input  logic              globalEn,
  output logic [WIDTH-1:0]  rdData,
  output logic              pending,
  output logic              irq
);
  localparam logic [MASK_W-1:0] MaskSel = MASK_W'(1) << MASK_BIT;
  localparam logic [WIDTH-1:0]  One     = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] compareQ;
  logic             matchNow;

  assign matchNow = (countQ == compareQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= wrData;
    end else begin
      countQ <= countQ + One;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= '0;
    end else if (strobes.loadCompare) begin
      compareQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobes.loadCompare) begin
      pending <= 1'b0;
    end else if (matchNow) begin
      pending <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.selCount)   rdData = countQ;
    if (strobes.selCompare) rdData = compareQ;
  end

  assign irq = pending && globalEn && (|(intMask & MaskSel));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCount |=> countQ == $past(countQ) + One);
  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> countQ == $past(wrData));
  // R6
  match_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && !strobes.loadCompare) |=> pending);
  // R6
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobes.loadCompare) |=> pending);
  // R7
  compare_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCompare |=> !pending);
  // R4
  compare_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCompare |=> $stable(compareQ));
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import timer_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 5,
  parameter int MASK_W      = 8,
  parameter int MASK_BIT    = 7,
  parameter int COUNT_REG   = 9,
  parameter int COMPARE_REG = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData,
  input  logic [MASK_W-1:0] intMask,
  input  logic              globalEn,
  output logic              timerPending,
  output logic              timerIrq
);
  timerStrobes_t strobes;

  timer_ctrl #(
    .ADDR_W(ADDR_W), .COUNT_REG(COUNT_REG), .COMPARE_REG(COMPARE_REG)
  ) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes)
  );

  timer_datapath #(
    .WIDTH(WIDTH), .MASK_W(MASK_W), .MASK_BIT(MASK_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .intMask(intMask), .globalEn(globalEn), .rdData(rdData),
    .pending(timerPending), .irq(timerIrq)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> (timerPending && globalEn && intMask[MASK_BIT]));
endmodule

// File: tb/tb_cycle_timer.sv
`timescale 1ns/1ps
module tb_cycle_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [7:0]  intMask = 8'h80;
  logic        globalEn = 1'b1;
  logic        timerPending;
  logic        timerIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cycle_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .intMask(intMask), .globalEn(globalEn),
    .timerPending(timerPending), .timerIrq(timerIrq)
  );

  typedef struct packed {
    logic [31:0] startVal;
    logic [31:0] cmpVal;
    logic [7:0]  waitCyc;
    logic        expPend;
  } vec_t;

  // Counter start, compare value, idle cycles, expected flag
  localparam vec_t VECS [6] = '{
    '{32'd100,        32'd105,    8'd3,  1'b0},
    '{32'd100,        32'd105,    8'd5,  1'b1},
    '{32'd100,        32'd103,    8'd10, 1'b1},
    '{32'hFFFF_FFFE,  32'd1,      8'd2,  1'b0},
    '{32'hFFFF_FFFE,  32'd0,      8'd2,  1'b1},
    '{32'h0000_1234,  32'h1234,   8'd8,  1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [4:0] num, input logic [31:0] val);
    wrEn = 1'b1; wrAddr = num; wrData = val;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] num, output logic [31:0] val);
    rdAddr = num;
    #1;
    val = rdData;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, c1;
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    readReg(5'd9, v);  check("R1 count in reset", v, 32'd0);
    readReg(5'd11, v); check("R1 compare in reset", v, 32'd0);
    check("R1 pending in reset", {31'd0, timerPending}, 32'd0);
    rstN = 1'b1;
    tick();

    // R2 free running increment
    readReg(5'd9, c0);
    repeat (7) tick();
    readReg(5'd9, c1);
    check("R2 increment over 7 cycles", c1, c0 + 32'd7);

    // Vector table: R3 R6 R2 wrap R9
    intMask = 8'h80; globalEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      regWrite(5'd9, VECS[i].startVal);
      regWrite(5'd11, VECS[i].cmpVal);
      repeat (int'(VECS[i].waitCyc)) tick();
      check($sformatf("R6 vec%0d pending", i), {31'd0, timerPending}, {31'd0, VECS[i].expPend});
      check($sformatf("R9 vec%0d irq", i), {31'd0, timerIrq}, {31'd0, VECS[i].expPend});
      readReg(5'd9, v);
      check($sformatf("R3 vec%0d count", i), v,
            VECS[i].startVal + 32'd1 + 32'(VECS[i].waitCyc));
    end

    // R3 load visible right after edge
    regWrite(5'd9, 32'd42);
    readReg(5'd9, v); check("R3 count load", v, 32'd42);

    // R7 counter write keeps flag
    regWrite(5'd11, 32'd50);
    regWrite(5'd9, 32'd48);
    repeat (3) tick();
    check("R6 match sets flag", {31'd0, timerPending}, 32'd1);
    regWrite(5'd9, 32'd1000);
    check("R7 count write keeps flag", {31'd0, timerPending}, 32'd1);

    // R9 masking combinations
    intMask = 8'h80; globalEn = 1'b1; #1;
    check("R9 mask7 en", {31'd0, timerIrq}, 32'd1);
    intMask = 8'h7F; globalEn = 1'b1; #1;
    check("R9 other bits only", {31'd0, timerIrq}, 32'd0);
    intMask = 8'hFF; globalEn = 1'b0; #1;
    check("R9 global disabled", {31'd0, timerIrq}, 32'd0);
    intMask = 8'h00; globalEn = 1'b1; #1;
    check("R9 mask clear", {31'd0, timerIrq}, 32'd0);
    intMask = 8'h80; globalEn = 1'b1;
    tick();

    // R7 compare write clears; R4 readback
    regWrite(5'd11, 32'd5000);
    check("R7 compare write clears", {31'd0, timerPending}, 32'd0);
    readReg(5'd11, v); check("R4 compare readback", v, 32'd5000);

    // R8 clear wins on the match edge
    regWrite(5'd11, 32'd700);
    regWrite(5'd9, 32'd700);
    regWrite(5'd11, 32'd900);
    check("R8 clear beats match", {31'd0, timerPending}, 32'd0);
    repeat (3) tick();
    check("R8 stays clear", {31'd0, timerPending}, 32'd0);

    // R10 unmapped writes ignored
    readReg(5'd9, c0);
    regWrite(5'd10, 32'h1234_5678);
    readReg(5'd9, c1);
    check("R10 count untouched", c1, c0 + 32'd1);
    regWrite(5'd12, 32'hDEAD_BEEF);
    readReg(5'd11, v); check("R10 compare untouched", v, 32'd900);
    check("R10 pending untouched", {31'd0, timerPending}, 32'd0);

    // R5 unmapped reads
    readReg(5'd10, v); check("R5 read num 10", v, 32'd0);
    readReg(5'd0, v);  check("R5 read num 0", v, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule